// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This controller sits at the home memory node of a small point-to-point multiprocessor. The home node owns a fixed, statically partitioned range of cache lines. For each line in that range it keeps a directory entry with three parts: a line state (uncached, shared or modified), the ID of the node that holds a dirty copy, and a bit-vector with one bit per node that marks which nodes hold clean copies. Request messages come in from the nodes on a valid/ready channel. The controller replies on one outgoing message channel and collects the nodes' replies on a third channel. It never broadcasts: coherence traffic goes only to the nodes that the directory entry names.

A plain read gives the requester a fill and adds it to the sharers. A read-exclusive request works in three steps. The controller first invalidates every other sharer. It then counts their acknowledgements back to zero. Only after that does it send the fill and record the requester as the single owner. When a line is held modified by another node, the controller first asks that owner for its data. For a read it asks the owner to downgrade, and for a read-exclusive it asks the owner to give the line up. The returned data is written into the small backing array before the fill is sent. The controller handles one transaction at a time, and new requests wait while a transaction is open.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0 and `rsp_ready` is 0. Every line is uncached, and backing line i holds the value i.
- R2: A read (`req_excl`=0) to an uncached or shared line produces exactly one message: a FILL (`out_kind`=0) to the requester, carrying the line's stored data. The requester is added to the sharers, and the line becomes shared.
- R3: A read-exclusive (`req_excl`=1) to a shared line sends one INV (`out_kind`=1) to each sharer other than the requester, in ascending node-ID order. The FILL is sent only after that many acknowledgements (`rsp_kind`=0) have arrived. The line then becomes modified, with the requester as owner and no sharers.
- R4: The requester never receives an INV. When there is no sharer other than the requester, the FILL is the only message sent.
- R5: A read to a line held modified by another node sends FETCH (`out_kind`=2) to the owner. The owner's data reply (`rsp_kind`=1) is written to the backing array, and the FILL to the requester carries that data. Afterward, both the owner and the requester are sharers.
- R6: A read-exclusive to a line held modified by another node sends RECALL (`out_kind`=3) to the owner. The returned data is written back and then forwarded in the FILL, and the requester becomes the sole owner.
- R7: A request from the node that already owns the line modified is answered with an immediate FILL. The line's state is left unchanged.
- R8: From the cycle a request is accepted until its FILL is taken, `req_ready` stays 0, so at most one transaction is open at a time.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outgoing message (`out_dst`, `out_kind`, `out_line`, `out_data`) holds steady. The message order is not changed by backpressure.
- R10: Transactions on one line leave the state and stored data of every other line untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller accepts a request |
| req_src | input | NID_W | Requesting node ID |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| req_line | input | LINE_W | Line index within the home range |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the outgoing message |
| out_dst | output | NID_W | Destination node |
| out_kind | output | 2 | 0 FILL, 1 INV, 2 FETCH, 3 RECALL |
| out_line | output | LINE_W | Line the message concerns |
| out_data | output | DATA_W | Line data (FILL only, else 0) |
| rsp_valid | input | 1 | Node reply present |
| rsp_ready | output | 1 | Controller takes a reply |
| rsp_src | input | NID_W | Replying node |
| rsp_kind | input | 1 | 0 invalidate acknowledgement, 1 data reply |
| rsp_data | input | DATA_W | Data carried by a data reply |

## Verification
The tests build one line up to three sharers with plain reads. A read-exclusive is then issued from one of those sharers, which separates "invalidate the others" from "invalidate everyone" and checks the ascending send order. Later tests cover a modified line read by a third node, the same line taken exclusively by a node that is already a sharer, and repeated requests from the current owner. Together these tell apart the four paths: fill at once, invalidate and count acknowledgements, downgrade fetch, and recall. Node replies come back with a delay, so an early fill or an accepted second request would show up. A backpressure window on the outgoing channel and a final read of an untouched line check that the order holds under stall and that the lines stay isolated.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        MSG_FILL   = 2'd0,
        MSG_INV    = 2'd1,
        MSG_FETCH  = 2'd2,
        MSG_RECALL = 2'd3
    } msg_kind_t;

    typedef enum logic [1:0] {
        LS_UNC = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_st_t;

    localparam logic RSP_ACK  = 1'b0;
    localparam logic RSP_DATA = 1'b1;
endpackage

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    localparam int NID_W  = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NID_W-1:0]  req_src,
    input  logic              req_excl,
    input  logic [LINE_W-1:0] req_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NID_W-1:0]  out_dst,
    output logic [1:0]        out_kind,
    output logic [LINE_W-1:0] out_line,
    output logic [DATA_W-1:0] out_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [NID_W-1:0]  rsp_src,
    input  logic              rsp_kind,
    input  logic [DATA_W-1:0] rsp_data
);
    localparam int CNT_W = NID_W + 1;

    typedef enum logic [2:0] {F_IDLE, F_INVAL, F_FETCH, F_WDATA, F_FILL} fsm_t;

    typedef struct {
        fsm_t              fsm;
        logic [NID_W-1:0]  src;
        logic              excl;
        logic [LINE_W-1:0] line;
        logic [NODES-1:0]  todo;
        logic [CNT_W-1:0]  acks;
        line_st_t          st  [LINES];
        logic [NID_W-1:0]  own [LINES];
        logic [NODES-1:0]  shr [LINES];
        logic [DATA_W-1:0] mem [LINES];
    } ctl_t;

    ctl_t d, q;

    logic [NID_W-1:0] inv_pick;
    logic [NODES-1:0] others;

    dir_lowest_pick #(.W(NODES), .IW(NID_W)) u_pick (
        .vec (q.todo),
        .idx (inv_pick)
    );

    always_comb begin
        d         = q;
        req_ready = (q.fsm == F_IDLE);
        rsp_ready = (q.fsm == F_INVAL) || (q.fsm == F_WDATA);
        out_valid = 1'b0;
        out_dst   = q.src;
        out_kind  = MSG_FILL;
        out_line  = q.line;
        out_data  = '0;
        others    = q.shr[req_line] & ~(NODES'(1) << req_src);
        case (q.fsm)
            F_IDLE: begin
                if (req_valid) begin
                    d.src  = req_src;
                    d.excl = req_excl;
                    d.line = req_line;
                    if (q.st[req_line] == LS_MOD && q.own[req_line] != req_src) begin
                        d.fsm = F_FETCH;
                    end else if (req_excl && q.st[req_line] == LS_SHR && others != '0) begin
                        d.fsm  = F_INVAL;
                        d.todo = others;
                        d.acks = CNT_W'($countones(others));
                    end else begin
                        d.fsm = F_FILL;
                    end
                end
            end
            F_INVAL: begin
                out_valid = (q.todo != '0);
                out_dst   = inv_pick;
                out_kind  = MSG_INV;
                if (out_valid && out_ready) d.todo[inv_pick] = 1'b0;
                if (rsp_valid && rsp_kind == RSP_ACK && q.acks != '0) d.acks = q.acks - 1'b1;
                if (d.todo == '0 && d.acks == '0) d.fsm = F_FILL;
            end
            F_FETCH: begin
                out_valid = 1'b1;
                out_dst   = q.own[q.line];
                out_kind  = q.excl ? MSG_RECALL : MSG_FETCH;
                if (out_ready) d.fsm = F_WDATA;
            end
            F_WDATA: begin
                if (rsp_valid && rsp_kind == RSP_DATA && rsp_src == q.own[q.line]) begin
                    d.mem[q.line] = rsp_data;
                    d.fsm         = F_FILL;
                end
            end
            F_FILL: begin
                out_valid = 1'b1;
                out_kind  = MSG_FILL;
                out_data  = q.mem[q.line];
                if (out_ready) begin
                    d.fsm = F_IDLE;
                    if (q.excl) begin
                        d.st[q.line]  = LS_MOD;
                        d.own[q.line] = q.src;
                        d.shr[q.line] = '0;
                    end else if (q.st[q.line] == LS_MOD) begin
                        if (q.own[q.line] != q.src) begin
                            d.st[q.line]  = LS_SHR;
                            d.shr[q.line] = (NODES'(1) << q.own[q.line]) | (NODES'(1) << q.src);
                        end
                    end else begin
                        d.st[q.line]  = LS_SHR;
                        d.shr[q.line] = q.shr[q.line] | (NODES'(1) << q.src);
                    end
                end
            end
            default: d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.fsm  <= F_IDLE;
            q.src  <= '0;
            q.excl <= 1'b0;
            q.line <= '0;
            q.todo <= '0;
            q.acks <= '0;
            for (int i = 0; i < LINES; i++) begin
                q.st[i]  <= LS_UNC;
                q.own[i] <= '0;
                q.shr[i] <= '0;
                q.mem[i] <= DATA_W'(i);
            end
        end else begin
            q <= d;
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_kind) && $stable(out_line) && $stable(out_data)); // R9

    AST_FILL_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == MSG_FILL |-> q.acks == '0 && q.todo == '0); // R3

    AST_NO_SELF_INV: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == MSG_INV |-> out_dst != q.src); // R4

    AST_ACK_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_kind == RSP_ACK |-> q.acks != '0); // R3

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && req_ready); // R1
endmodule

// File: tb/home_dir_ctrl_bench.sv
module home_dir_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4;
    localparam int LINES = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_excl = 1'b0;
    logic [1:0] req_src = '0;
    logic [2:0] req_line = '0;
    logic out_valid, out_ready = 1'b1;
    logic [1:0] out_dst, out_kind;
    logic [2:0] out_line;
    logic [15:0] out_data;
    logic rsp_valid = 1'b0, rsp_ready, rsp_kind = 1'b0;
    logic [1:0] rsp_src = '0;
    logic [15:0] rsp_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    home_dir_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_home_dir_ctrl (
        .clk, .rst_n, .req_valid, .req_ready, .req_src, .req_excl, .req_line,
        .out_valid, .out_ready, .out_dst, .out_kind, .out_line, .out_data,
        .rsp_valid, .rsp_ready, .rsp_src, .rsp_kind, .rsp_data
    );

    typedef struct {
        logic [1:0]  dst;
        logic [1:0]  kind;
        logic [2:0]  line;
        logic [15:0] data;
        string       tag;
    } msg_t;

    typedef struct {
        logic [1:0]  src;
        logic        kind;
        logic [15:0] data;
    } rsp_t;

    msg_t exp_q[$];
    rsp_t rsp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   hold_cnt = 0;
    int   gap = 0;
    bit   rsp_pend = 1'b0;

    // bench-side directory model: 0 uncached, 1 shared, 2 modified
    int          m_st  [LINES];
    logic [1:0]  m_own [LINES];
    logic [3:0]  m_shr [LINES];
    logic [15:0] m_mem [LINES];

    function automatic logic [15:0] owner_val(logic [1:0] n, logic [2:0] l);
        return {4'hA, 2'b00, n, 5'b0, l};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic void push(logic [1:0] dst, logic [1:0] kind, logic [2:0] line, logic [15:0] data, string tag);
        msg_t m;
        m.dst = dst; m.kind = kind; m.line = line; m.data = data; m.tag = tag;
        exp_q.push_back(m);
    endfunction

    // monitor, node responder and output backpressure in one negedge process
    always @(negedge clk) begin
        if (rsp_pend) begin
            rsp_valid = 1'b0;
            void'(rsp_q.pop_front());
            gap = 3;
        end
        if (gap > 0) gap--;
        else if (!rsp_valid && rsp_q.size() > 0) begin
            rsp_valid = 1'b1;
            rsp_src   = rsp_q[0].src;
            rsp_kind  = rsp_q[0].kind;
            rsp_data  = rsp_q[0].data;
        end
        rsp_pend = rsp_valid && rsp_ready;

        out_ready = (hold_cnt == 0);
        if (hold_cnt > 0) hold_cnt--;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected message kind", 32'(out_kind), 32'hF);
            end else begin
                msg_t e;
                e = exp_q.pop_front();
                check(out_dst == e.dst, e.tag, "dst", 32'(out_dst), 32'(e.dst));
                check(out_kind == e.kind, e.tag, "kind", 32'(out_kind), 32'(e.kind));
                check(out_line == e.line, e.tag, "line", 32'(out_line), 32'(e.line));
                check(out_data == e.data, e.tag, "data", 32'(out_data), 32'(e.data));
            end
            if (out_kind == 2'd1) begin
                rsp_t r; r.src = out_dst; r.kind = 1'b0; r.data = '0; rsp_q.push_back(r);
            end else if (out_kind != 2'd0) begin
                rsp_t r; r.src = out_dst; r.kind = 1'b1; r.data = owner_val(out_dst, out_line); rsp_q.push_back(r);
            end
        end
    end

    task automatic do_req(logic [1:0] src, bit excl, logic [2:0] line, string tag);
        logic [3:0] me;
        me = 4'(1) << src;
        if (m_st[line] == 2 && m_own[line] != src) begin
            logic [1:0] ow;
            ow = m_own[line];
            push(ow, excl ? 2'd3 : 2'd2, line, 16'h0, tag);
            m_mem[line] = owner_val(ow, line);
            push(src, 2'd0, line, m_mem[line], tag);
            if (excl) begin m_own[line] = src; m_shr[line] = '0; end
            else begin m_st[line] = 1; m_shr[line] = (4'(1) << ow) | me; end
        end else if (m_st[line] == 2) begin
            push(src, 2'd0, line, m_mem[line], tag);
        end else begin
            if (excl) begin
                for (int n = 0; n < NODES; n++)
                    if (m_shr[line][n] && n != int'(src)) push(2'(n), 2'd1, line, 16'h0, tag);
                push(src, 2'd0, line, m_mem[line], tag);
                m_st[line] = 2; m_own[line] = src; m_shr[line] = '0;
            end else begin
                push(src, 2'd0, line, m_mem[line], tag);
                m_st[line] = 1; m_shr[line] = m_shr[line] | me;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_excl = excl; req_line = line;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", "req_ready while busy", 32'(req_ready), 32'h0);
        for (int w = 0; w < 400; w++) begin
            if (exp_q.size() == 0 && rsp_q.size() == 0 && !rsp_valid && req_ready) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, tag, "messages left unseen", 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_own[i] = '0; m_shr[i] = '0; m_mem[i] = 16'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        check(rsp_ready == 1'b0, "R1", "rsp_ready after reset", 32'(rsp_ready), 32'h0);

        do_req(2'd0, 1'b0, 3'd2, "R2");   // uncached read, reset data 2
        do_req(2'd1, 1'b0, 3'd2, "R2");   // shared read
        do_req(2'd3, 1'b0, 3'd2, "R2");   // third sharer
        do_req(2'd1, 1'b1, 3'd2, "R3");   // invalidate 0 then 3, skip requester 1
        do_req(2'd2, 1'b0, 3'd2, "R5");   // fetch from owner 1
        do_req(2'd2, 1'b1, 3'd2, "R4");   // only node 1 invalidated, never 2
        do_req(2'd2, 1'b1, 3'd2, "R7");   // owner again: immediate fill
        do_req(2'd0, 1'b1, 3'd2, "R6");   // recall from owner 2
        do_req(2'd0, 1'b0, 3'd2, "R7");   // owner read, stays modified
        do_req(2'd3, 1'b1, 3'd5, "R4");   // exclusive on uncached line: fill only
        do_req(2'd1, 1'b0, 3'd5, "R5");   // fetch from owner 3
        hold_cnt = 6;
        do_req(2'd1, 1'b1, 3'd5, "R9");   // invalidate 3 under output backpressure
        do_req(2'd0, 1'b0, 3'd2, "R7");   // line 2 still owned by 0 after line 5 traffic
        do_req(2'd2, 1'b0, 3'd7, "R10");  // untouched line keeps reset value 7
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule